// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Compare Channels

This block is a free-running 16-bit up-counter with a parameterised number of 16-bit compare channels. An 8-bit processor bus reaches all of it. The counter and each compare value occupy a pair of byte addresses: the low byte at the even offset and the high byte at the odd offset. One shared byte-wide holding register lets software move a whole 16-bit word in a single step. A high-byte write only loads the holding register. The low-byte write that follows commits both bytes to the target in the same cycle. For a read, software fetches the low byte first. That access latches the target's high byte into the holding register, and the high-byte read then returns the latched copy.

The counter advances by one on each cycle that the timer-clock enable is high. On a timer-clock cycle where the counter equals a channel's compare value, that channel records a match. The match sets a sticky flag and toggles the channel's waveform pin. A processor write to the counter blanks matches on every channel for the next timer-clock cycle. This prevents a spurious match when software reloads the counter.

Top module: `tmr16_byte_access`

## Requirements
- R1: After reset the counter, every compare value, the holding byte, every match flag and every waveform output read as zero.
- R2: The counter increments by one on each clock cycle with `tick` high and holds its value on cycles with `tick` low.
- R3: The counter wraps from 0xFFFF to 0x0000 on a tick.
- R4: Byte offsets from `BASE_ADDR` (default 0x40) are as follows: counter low at 0 and high at 1; compare channel k low at 2+2k and high at 3+2k. A write to an odd (high) offset loads only the holding byte and leaves the target unchanged. A write to the even (low) offset loads {holding byte, written byte} into the target in one cycle.
- R5: A read at an even offset returns the target's live low byte and copies the target's high byte into the holding byte. A read at an odd offset returns the holding byte.
- R6: One holding byte serves all register pairs. A high write to one pair followed by a low write to another pair commits the first pair's byte into the second target. A low read of any pair replaces the held byte.
- R7: On a tick cycle where the counter equals channel k's compare value and blanking is not in effect, flag bit k sets on the next edge and stays set.
- R8: The flag byte sits at offset 2+2·NUM_CMP, with channel k in bit k. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R9: Each channel's waveform output toggles on every unblocked match and is otherwise stable.
- R10: After any processor write to the counter, the next tick raises no match on any channel, although the counter still increments on that tick. Later ticks match normally.
- R11: When a counter write and a tick fall in the same cycle, the written value is loaded and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timer-clock enable |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Byte read strobe (has a side effect on low-byte reads) |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| match_flag | output | NUM_CMP | Sticky match flags |
| wave_out | output | NUM_CMP | Waveform outputs |

## Verification
The embedded properties cover the following on every cycle:
- the counter holds without a tick, loads written words and wraps;
- the holding byte loads on high writes and snapshots on low reads;
- a low write reaches at most one target;
- flags stay set until cleared;
- waveforms stay quiet on idle or blanked ticks.

The directed scenarios cover what needs a full byte sequence. These are the two-step atomic read against a counter that moves between the two accesses, cross-pair use of the holding byte, write-one-to-clear, and the sequence of a blanked tick followed by a normal match. They also cover write-over-tick priority.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // Target of a decoded byte access
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CNT  = 2'd1,
    TGT_CMP  = 2'd2,
    TGT_FLAG = 2'd3
  } tgt_e;

  // Counter is always two bytes wide
  localparam int BYTES_PER_WORD = 2;
  // Offset of the first compare pair in the byte map
  localparam int CMP_PAIR_FIRST = 1;
endpackage

// File: rtl/tmr16_regif.sv
module tmr16_regif
  import tmr16_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          NUM_CMP   = 2,
  parameter logic [7:0]  BASE_ADDR = 8'h40
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [7:0]                         addr,
  input  logic                               wr_en,
  input  logic [BYTE_W-1:0]                  wr_data,
  input  logic                               rd_en,
  output logic [BYTE_W-1:0]                  rd_data,
  input  logic [2*BYTE_W-1:0]                cnt_q,
  input  logic [NUM_CMP-1:0][2*BYTE_W-1:0]   cmp_q,
  input  logic [NUM_CMP-1:0]                 flag_q,
  output logic                               cnt_wr,
  output logic [NUM_CMP-1:0]                 cmp_wr,
  output logic [2*BYTE_W-1:0]                wr_word,
  output logic [NUM_CMP-1:0]                 flag_clr
);
  localparam int         WORD_W   = BYTES_PER_WORD * BYTE_W;
  localparam logic [7:0] FLAG_OFS = 8'(2 + 2 * NUM_CMP);

  logic [7:0]          off;
  logic                hi_sel;
  logic                hit_cnt;
  logic [NUM_CMP-1:0]  hit_cmp;
  logic                hit_pair;
  logic                hit_flag;
  tgt_e                tgt;
  logic [WORD_W-1:0]   pair_word;
  logic [BYTE_W-1:0]   temp_q, temp_d;
  logic                lo_write;

  // Address decode
  always_comb begin
    off      = addr - BASE_ADDR;
    hi_sel   = off[0];
    hit_cnt  = (off[7:1] == 7'd0);
    hit_cmp  = '0;
    pair_word = '0;
    if (hit_cnt) pair_word = cnt_q;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (off[7:1] == 7'(k + CMP_PAIR_FIRST)) begin
        hit_cmp[k] = 1'b1;
        pair_word  = cmp_q[k];
      end
    end
    hit_pair = hit_cnt | (|hit_cmp);
    hit_flag = (off == FLAG_OFS);
    if (hit_cnt)        tgt = TGT_CNT;
    else if (|hit_cmp)  tgt = TGT_CMP;
    else if (hit_flag)  tgt = TGT_FLAG;
    else                tgt = TGT_NONE;
  end

  // Write strobes
  always_comb begin
    lo_write = wr_en & hit_pair & ~hi_sel;
    cnt_wr   = lo_write & (tgt == TGT_CNT);
    cmp_wr   = {NUM_CMP{lo_write}} & hit_cmp;
    wr_word  = {temp_q, wr_data};
    flag_clr = '0;
    if (wr_en && tgt == TGT_FLAG) flag_clr = wr_data[NUM_CMP-1:0];
  end

  // Read mux
  always_comb begin
    rd_data = '0;
    if (tgt == TGT_FLAG) begin
      rd_data[NUM_CMP-1:0] = flag_q;
    end else if (hit_pair) begin
      rd_data = hi_sel ? temp_q : pair_word[BYTE_W-1:0];
    end
  end

  // Shared holding byte: next state
  always_comb begin
    temp_d = temp_q;
    if (wr_en && hit_pair && hi_sel)
      temp_d = wr_data;
    else if (rd_en && !wr_en && hit_pair && !hi_sel)
      temp_d = pair_word[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) temp_q <= '0;
    else        temp_q <= temp_d;
  end

  assert_hi_write_loads_temp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_pair && hi_sel) |=> (temp_q == $past(wr_data)));

  assert_lo_read_snapshots_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && hit_pair && !hi_sel) |=> (temp_q == $past(pair_word[WORD_W-1:BYTE_W])));

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_wr, cmp_wr}));
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_word,
  output logic [CNT_W-1:0] cnt_q,
  output logic             blank_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             blank_d;

  always_comb begin
    cnt_d   = cnt_q;
    blank_d = blank_q;
    if (cnt_wr) begin
      cnt_d   = wr_word;
      blank_d = 1'b1;
    end else if (tick) begin
      cnt_d   = cnt_q + 1'b1;
      blank_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blank_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blank_q <= blank_d;
    end
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_word)));

  assert_write_blanks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> blank_q);
endmodule

// File: rtl/tmr16_cmp_unit.sv
module tmr16_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             blank,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wr_word,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_q,
  output logic             flag_q,
  output logic             wave_q
);
  logic [CNT_W-1:0] cmp_d;
  logic             flag_d;
  logic             wave_d;
  logic             match_ev;

  always_comb begin
    match_ev = tick & ~blank & ~cnt_wr & (cnt_q == cmp_q);
    cmp_d    = cmp_wr ? wr_word : cmp_q;
    flag_d   = match_ev | (flag_q & ~flag_clr);
    wave_d   = wave_q ^ match_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      wave_q <= wave_d;
    end
  end

  assert_cmp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (cmp_q == $past(wr_word)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tick) |=> !flag_q);

  assert_wave_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_q));

  assert_blank_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blank) |=> $stable(wave_q));
endmodule

// File: rtl/tmr16_byte_access.sv
module tmr16_byte_access #(
  parameter int         BYTE_W    = 8,
  parameter int         NUM_CMP   = 2,
  parameter logic [7:0] BASE_ADDR = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [7:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [BYTE_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [BYTE_W-1:0]  bus_rdata,
  output logic [NUM_CMP-1:0] match_flag,
  output logic [NUM_CMP-1:0] wave_out
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0]                      rst_sync;
  logic                            rst_int_n;
  logic [CNT_W-1:0]                cnt_q;
  logic                            blank_q;
  logic                            cnt_wr;
  logic [CNT_W-1:0]                wr_word;
  logic [NUM_CMP-1:0]              cmp_wr;
  logic [NUM_CMP-1:0]              flag_clr;
  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_q;
  logic [NUM_CMP-1:0]              flag_q;
  logic [NUM_CMP-1:0]              wave_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tmr16_regif #(
    .BYTE_W(BYTE_W), .NUM_CMP(NUM_CMP), .BASE_ADDR(BASE_ADDR)
  ) u_regif (
    .clk(clk), .rst_n(rst_int_n),
    .addr(bus_addr), .wr_en(bus_wr), .wr_data(bus_wdata),
    .rd_en(bus_rd), .rd_data(bus_rdata),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .flag_q(flag_q),
    .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wr_word(wr_word), .flag_clr(flag_clr)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_int_n), .tick(tick),
    .cnt_wr(cnt_wr), .wr_word(wr_word),
    .cnt_q(cnt_q), .blank_q(blank_q)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    tmr16_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_int_n), .tick(tick),
      .blank(blank_q), .cnt_wr(cnt_wr), .cnt_q(cnt_q),
      .cmp_wr(cmp_wr[k]), .wr_word(wr_word), .flag_clr(flag_clr[k]),
      .cmp_q(cmp_q[k]), .flag_q(flag_q[k]), .wave_q(wave_q[k])
    );
  end

  assign match_flag = flag_q;
  assign wave_out   = wave_q;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (cnt_q == '0 && flag_q == '0 && wave_q == '0));
endmodule

// File: tb/tmr16_byte_access_test.sv
module tmr16_byte_access_test;
  localparam logic [7:0] CNT_LO = 8'h40, CNT_HI = 8'h41;
  localparam logic [7:0] A_LO = 8'h42, A_HI = 8'h43;
  localparam logic [7:0] B_LO = 8'h44, B_HI = 8'h45;
  localparam logic [7:0] FLAGS = 8'h46;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [1:0] match_flag;
  logic [1:0] wave_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr16_byte_access uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .match_flag(match_flag), .wave_out(wave_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic write16(input logic [7:0] lo, input logic [15:0] v);
    bus_write(lo + 8'd1, v[15:8]);
    bus_write(lo, v[7:0]);
  endtask

  task automatic read16(input logic [7:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    bus_read(lo, l);
    bus_read(lo + 8'd1, h);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    read16(CNT_LO, v); check("R1 counter", v, 16'h0);
    read16(A_LO, v);   check("R1 compare A", v, 16'h0);
    read16(B_LO, v);   check("R1 compare B", v, 16'h0);
    check("R1 flags", {14'd0, match_flag}, 16'h0);
    check("R1 waves", {14'd0, wave_out}, 16'h0);
  endtask

  task automatic t_atomic_write;
    logic [15:0] v;
    bus_write(B_HI, 8'h77); bus_write(B_LO, 8'h77);
    bus_write(A_HI, 8'hAB);
    read16(A_LO, v); check("R4 high write leaves target", v, 16'h0);
    write16(A_LO, 16'hABCD);
    read16(A_LO, v); check("R4 committed word", v, 16'hABCD);
  endtask

  task automatic t_shared_temp;
    logic [15:0] v;
    logic [7:0] b;
    bus_write(B_HI, 8'h5A);
    bus_write(CNT_LO, 8'h3C);
    read16(CNT_LO, v); check("R6 cross-pair commit", v, 16'h5A3C);
    bus_read(A_LO, b);
    bus_read(CNT_HI, b); check("R6 low read replaces held byte", {8'd0, b}, 16'h00AB);
  endtask

  task automatic t_snapshot;
    logic [7:0] l, h;
    logic [15:0] v;
    write16(CNT_LO, 16'h12FF);
    bus_read(CNT_LO, l); check("R5 live low byte", {8'd0, l}, 16'h00FF);
    ticks(1);
    bus_read(CNT_HI, h); check("R5 high from snapshot", {8'd0, h}, 16'h0012);
    read16(CNT_LO, v); check("R5 fresh read after tick", v, 16'h1300);
  endtask

  task automatic t_count;
    logic [15:0] v;
    write16(CNT_LO, 16'h0100);
    ticks(5);
    read16(CNT_LO, v); check("R2 five ticks", v, 16'h0105);
    repeat (4) @(negedge clk);
    read16(CNT_LO, v); check("R2 hold without tick", v, 16'h0105);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    write16(CNT_LO, 16'hFFFE);
    ticks(1);
    read16(CNT_LO, v); check("R3 reach max", v, 16'hFFFF);
    ticks(1);
    read16(CNT_LO, v); check("R3 wrap to zero", v, 16'h0000);
  endtask

  task automatic t_write_vs_tick;
    logic [15:0] v;
    bus_write(CNT_HI, 8'h00);
    @(negedge clk);
    bus_addr = CNT_LO; bus_wdata = 8'h40; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    read16(CNT_LO, v); check("R11 write beats tick", v, 16'h0040);
  endtask

  task automatic t_match;
    write16(A_LO, 16'h0010);
    write16(B_LO, 16'h0012);
    write16(CNT_LO, 16'h000E);
    bus_write(FLAGS, 8'h03);
    check("R8 flags cleared", {14'd0, match_flag}, 16'h0);
    ticks(2);
    check("R7 no early match", {14'd0, match_flag}, 16'h0);
    ticks(1);
    check("R7 flag A set", {14'd0, match_flag}, 16'h1);
    check("R9 wave A toggled", {14'd0, wave_out}, 16'h1);
    ticks(2);
    check("R7 flag B set, A sticky", {14'd0, match_flag}, 16'h3);
    check("R9 wave B toggled", {14'd0, wave_out}, 16'h3);
  endtask

  task automatic t_flag_clear;
    logic [7:0] b;
    bus_write(FLAGS, 8'h00);
    check("R8 zero write no effect", {14'd0, match_flag}, 16'h3);
    bus_write(FLAGS, 8'h01);
    check("R8 clear bit 0 only", {14'd0, match_flag}, 16'h2);
    bus_read(FLAGS, b);
    check("R8 flag byte read", {8'd0, b}, 16'h0002);
  endtask

  task automatic t_blank;
    logic [15:0] v;
    bus_write(FLAGS, 8'h03);
    write16(CNT_LO, 16'h0010);
    ticks(1);
    check("R10 channel A blanked", {14'd0, match_flag}, 16'h0);
    check("R10 waves unchanged", {14'd0, wave_out}, 16'h3);
    read16(CNT_LO, v); check("R10 counter still ticks", v, 16'h0011);
    write16(CNT_LO, 16'h0012);
    ticks(1);
    check("R10 channel B blanked", {14'd0, match_flag}, 16'h0);
    write16(CNT_LO, 16'h000F);
    ticks(2);
    check("R10 later tick matches", {14'd0, match_flag}, 16'h1);
    check("R9 wave A toggles back", {14'd0, wave_out}, 16'h2);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_atomic_write();
    t_shared_temp();
    t_snapshot();
    t_count();
    t_wrap();
    t_write_vs_tick();
    t_match();
    t_flag_clear();
    t_blank();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule